// File: doc/BRIEF.md
# Enhanced Parallel Port Transfer Gate

This block sits behind a printer port register set and turns host accesses to the two enhanced-port offsets into byte handshakes on a simple peripheral request/acknowledge interface. An access at offset 3 runs an address cycle. An access at offset 4 runs a data cycle and may be 8, 16 or 32 bits wide. Wider accesses are split into bytes and sent least significant byte first. A transfer starts only when the stored control register holds the exact idle pattern that matches the access direction. Any other control state makes the access a no-op.

Each byte waits a bounded number of clocks for the acknowledge. If the wait runs out, the block sets a sticky timeout flag, drops the rest of the access and releases the host. The flag appears in bit 0 of the status read. Only a status write with bit 0 set clears it. The block also keeps the data, control and status registers that decide the gating. It raises one-cycle events when the data byte or the control byte actually changes, and a separate event when the direction bit flips.

The host holds `req_i` with its command until `ready_o` pulses for one cycle. For reads, `rdata_o` is valid in that same cycle.

Top module: `ppx_epp_gate`

## Requirements
- R1: After reset the data register reads 0xFF, the control register reads 0xCC and the status read shows bit 0 (timeout) as 0.
- R2: A control write (offset 2) stores the written byte with bits 7:6 forced to 1, and reads back that way. `ctrl_upd_o` pulses only when the stored value changes.
- R3: `dir_chg_o` pulses together with `ctrl_upd_o` exactly when control bit 5 (direction) changes value.
- R4: A data write (offset 0) whose byte differs from the stored byte updates it and pulses `data_upd_o`. A write of the same byte produces no pulse. Offset 0 reads return the stored byte.
- R5: A status read (offset 1) returns `pstat_i[7:1]` in bits 7:1 and the timeout flag in bit 0.
- R6: A status write with bit 0 set clears the timeout flag. A status write with bit 0 clear leaves the flag unchanged.
- R7: A write at offset 3 or 4 starts a peripheral transfer only when control bits {5,3,2,1,0} equal 0x04 after masking with 0x2F. Otherwise no request is issued.
- R8: A read at offset 3 or 4 starts a transfer only when the masked control value equals 0x24. Otherwise no request is issued and the read returns all ones at the access width (0xFF, 0xFFFF or 0xFFFFFFFF for size 0, 1, 2).
- R9: Offset 3 transfers drive `pr_addr_o`=1 and offset 4 transfers drive `pr_addr_o`=0. `pr_wr_o` is 1 for host writes and 0 for host reads.
- R10: At offset 4, size 0/1/2 moves 1/2/4 bytes. Byte 0 (bits 7:0) goes first and read bytes are assembled into the same little-endian lanes.
- R11: A byte that sees no `pr_ack_i` within TMO_CYCLES clocks of request (default 16) sets the timeout flag and ends the access. Remaining bytes are not requested, and lanes not received read as ones.
- R12: `ready_o` is a single-cycle pulse per host access and is never high while `pr_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until ready_o |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 3 | Register offset |
| size_i | input | 2 | Access width at offset 4: 0 byte, 1 half, 2 word |
| wdata_i | input | 32 | Host write data |
| ready_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Host read data, valid with ready_o |
| pstat_i | input | 8 | Live peripheral status lines |
| data_o | output | 8 | Stored data byte |
| data_upd_o | output | 1 | Data byte changed event |
| ctrl_o | output | 8 | Stored control byte |
| ctrl_upd_o | output | 1 | Control byte changed event |
| dir_chg_o | output | 1 | Direction bit changed event |
| pr_req_o | output | 1 | Peripheral byte request |
| pr_addr_o | output | 1 | Address cycle (1) or data cycle (0) |
| pr_wr_o | output | 1 | Peripheral write (1) or read (0) |
| pr_wdata_o | output | 8 | Byte sent to the peripheral |
| pr_ack_i | input | 1 | Peripheral acknowledge, one cycle per byte |
| pr_rdata_i | input | 8 | Byte from the peripheral, valid with pr_ack_i |

## Verification
Register accesses and gated-off enhanced accesses finish with `ready_o` one clock after the edge that accepts them. The change events rise in that same cycle. Enhanced transfers raise `pr_req_o` one clock after acceptance. An acknowledge driven in the k-th cycle of a byte completes that byte at the following edge. A timeout ends the access after exactly TMO_CYCLES clocks of one byte, and `ready_o` follows on the next cycle. The bench drives on falling edges and waits for the falling edge where `ready_o` is first high, then reads data, events and the peripheral log there. A further falling edge confirms that `ready_o` has dropped. Acknowledge delays of 16 and 17 pin the pass/fail boundary.

// File: rtl/ppx_pkg.sv
package ppx_pkg;
  localparam int unsigned HOST_DW = 32;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_STAT  = 3'd1;
  localparam logic [2:0] OFS_CTRL  = 3'd2;
  localparam logic [2:0] OFS_EADDR = 3'd3;
  localparam logic [2:0] OFS_EDATA = 3'd4;

  localparam logic [7:0] CTRL_GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR        = 8'h04;
  localparam logic [7:0] GATE_RD        = 8'h24;
  localparam logic [7:0] CTRL_FIXED     = 8'hC0;
  localparam logic [7:0] CTRL_RST       = 8'hCC;
  localparam int unsigned DIR_BIT       = 5;

  function automatic logic [HOST_DW-1:0] lane_mask(input int unsigned last);
    logic [HOST_DW-1:0] m;
    for (int i = 0; i < int'(HOST_DW / 8); i++)
      m[8*i +: 8] = (i <= int'(last)) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/ppx_regs.sv
module ppx_regs
  import ppx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic       we_i,
  input  logic [2:0] ofs_i,
  input  logic [7:0] wbyte_i,
  input  logic [7:0] pstat_i,
  input  logic       tmo_set_i,
  output logic [7:0] rbyte_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] data_o,
  output logic       tmo_o,
  output logic       data_upd_o,
  output logic       ctrl_upd_o,
  output logic       dir_chg_o
);
  logic [7:0] data_q, ctrl_q, ctrl_new;
  logic       tmo_q, wr, tmo_clr;

  assign wr       = acc_i && we_i;
  assign ctrl_new = wbyte_i | CTRL_FIXED;
  assign tmo_clr  = wr && (ofs_i == OFS_STAT) && wbyte_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q     <= 8'hFF;
      ctrl_q     <= CTRL_RST;
      tmo_q      <= 1'b0;
      data_upd_o <= 1'b0;
      ctrl_upd_o <= 1'b0;
      dir_chg_o  <= 1'b0;
    end else begin
      data_upd_o <= 1'b0;
      ctrl_upd_o <= 1'b0;
      dir_chg_o  <= 1'b0;
      if (wr && ofs_i == OFS_DATA && wbyte_i != data_q) begin
        data_q     <= wbyte_i;
        data_upd_o <= 1'b1;
      end
      if (wr && ofs_i == OFS_CTRL && ctrl_new != ctrl_q) begin
        ctrl_q     <= ctrl_new;
        ctrl_upd_o <= 1'b1;
        dir_chg_o  <= ctrl_new[DIR_BIT] ^ ctrl_q[DIR_BIT];
      end
      if (tmo_set_i)    tmo_q <= 1'b1;
      else if (tmo_clr) tmo_q <= 1'b0;
    end
  end

  always_comb begin
    case (ofs_i)
      OFS_DATA: rbyte_o = data_q;
      OFS_STAT: rbyte_o = {pstat_i[7:1], tmo_q};
      OFS_CTRL: rbyte_o = ctrl_q;
      default:  rbyte_o = 8'hFF;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;
  assign tmo_o  = tmo_q;

  p_ctrl_upd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_upd_o |-> ctrl_q != $past(ctrl_q));
  p_dir_chg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_chg_o |-> ctrl_q[DIR_BIT] != $past(ctrl_q[DIR_BIT]));
  p_data_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_upd_o |-> data_q != $past(data_q));
  p_tmo_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tmo_q) |-> $past(acc_i && we_i && ofs_i == OFS_STAT && wbyte_i[0]));
endmodule

// File: rtl/ppx_xfer.sv
module ppx_xfer #(
  parameter int unsigned TMO_CYCLES = 16,
  parameter int unsigned NB         = 4,
  localparam int unsigned CW        = $clog2(TMO_CYCLES + 1),
  localparam int unsigned IW        = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            rd_i,
  input  logic            acyc_i,
  input  logic [IW-1:0]   last_i,
  input  logic [8*NB-1:0] wdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fail_o,
  output logic [8*NB-1:0] rdata_o,
  output logic            pr_req_o,
  output logic            pr_addr_o,
  output logic            pr_wr_o,
  output logic [7:0]      pr_wdata_o,
  input  logic            pr_ack_i,
  input  logic [7:0]      pr_rdata_i
);
  logic            busy_q, rd_q, acyc_q;
  logic [IW-1:0]   last_q, idx_q;
  logic [CW-1:0]   cnt_q;
  logic [8*NB-1:0] wbuf_q, rbuf_q, rnext;
  logic            got, expired;

  assign got     = busy_q && pr_ack_i;
  assign expired = cnt_q == CW'(TMO_CYCLES - 1);
  assign fail_o  = busy_q && !pr_ack_i && expired;
  assign done_o  = (got && idx_q == last_q) || fail_o;

  for (genvar g = 0; g < int'(NB); g++) begin : g_lane
    assign rnext[8*g +: 8] = (got && rd_q && idx_q == IW'(g)) ? pr_rdata_i : rbuf_q[8*g +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      acyc_q <= 1'b0;
      last_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      wbuf_q <= '0;
      rbuf_q <= '1;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= rd_i;
      acyc_q <= acyc_i;
      last_q <= last_i;
      idx_q  <= '0;
      cnt_q  <= '0;
      wbuf_q <= wdata_i;
      rbuf_q <= '1;
    end else if (busy_q) begin
      rbuf_q <= rnext;
      if (done_o) begin
        busy_q <= 1'b0;
      end else if (got) begin
        idx_q <= idx_q + 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign rdata_o    = rnext;
  assign pr_req_o   = busy_q;
  assign pr_addr_o  = busy_q && acyc_q;
  assign pr_wr_o    = busy_q && !rd_q;
  assign pr_wdata_o = wbuf_q[{idx_q, 3'b000} +: 8];

  p_cnt_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < CW'(TMO_CYCLES));
  p_fail_abandon_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !pr_req_o);
  p_byte_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_req_o && $past(pr_req_o) && !$past(pr_ack_i)) |-> $stable(pr_wdata_o));
endmodule

// File: rtl/ppx_epp_gate.sv
module ppx_epp_gate
  import ppx_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic        ready_o,
  output logic [31:0] rdata_o,
  input  logic [7:0]  pstat_i,
  output logic [7:0]  data_o,
  output logic        data_upd_o,
  output logic [7:0]  ctrl_o,
  output logic        ctrl_upd_o,
  output logic        dir_chg_o,
  output logic        pr_req_o,
  output logic        pr_addr_o,
  output logic        pr_wr_o,
  output logic [7:0]  pr_wdata_o,
  input  logic        pr_ack_i,
  input  logic [7:0]  pr_rdata_i
);
  localparam int unsigned NB = HOST_DW / 8;
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;

  logic [IW-1:0]      last_idx;
  logic [HOST_DW-1:0] acc_mask, mask_q, eng_rdata, simple_rd;
  logic [7:0]         rbyte;
  logic               is_epp, gate_ok, accept, start, simple;
  logic               eng_busy, eng_done, eng_fail, xrd_q, ready_q, tmo;
  logic [HOST_DW-1:0] rdata_q;

  always_comb begin
    last_idx = '0;
    if (addr_i == OFS_EDATA) begin
      case (size_i)
        2'd0:    last_idx = '0;
        2'd1:    last_idx = IW'(1);
        default: last_idx = IW'(NB - 1);
      endcase
    end
  end

  assign acc_mask  = lane_mask(int'(last_idx));
  assign is_epp    = (addr_i == OFS_EADDR) || (addr_i == OFS_EDATA);
  assign gate_ok   = (ctrl_o & CTRL_GATE_MASK) == (we_i ? GATE_WR : GATE_RD);
  assign accept    = req_i && !ready_q && !eng_busy;
  assign start     = accept && is_epp && gate_ok;
  assign simple    = accept && !start;
  assign simple_rd = is_epp ? acc_mask : {{(HOST_DW-8){1'b0}}, rbyte};

  ppx_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (simple),
    .we_i       (we_i),
    .ofs_i      (addr_i),
    .wbyte_i    (wdata_i[7:0]),
    .pstat_i    (pstat_i),
    .tmo_set_i  (eng_fail),
    .rbyte_o    (rbyte),
    .ctrl_o     (ctrl_o),
    .data_o     (data_o),
    .tmo_o      (tmo),
    .data_upd_o (data_upd_o),
    .ctrl_upd_o (ctrl_upd_o),
    .dir_chg_o  (dir_chg_o)
  );

  ppx_xfer #(.TMO_CYCLES(TMO_CYCLES), .NB(NB)) u_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .rd_i       (!we_i),
    .acyc_i     (addr_i == OFS_EADDR),
    .last_i     (last_idx),
    .wdata_i    (wdata_i),
    .busy_o     (eng_busy),
    .done_o     (eng_done),
    .fail_o     (eng_fail),
    .rdata_o    (eng_rdata),
    .pr_req_o   (pr_req_o),
    .pr_addr_o  (pr_addr_o),
    .pr_wr_o    (pr_wr_o),
    .pr_wdata_o (pr_wdata_o),
    .pr_ack_i   (pr_ack_i),
    .pr_rdata_i (pr_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
      mask_q  <= '0;
      xrd_q   <= 1'b0;
    end else begin
      ready_q <= simple || eng_done;
      if (start) begin
        mask_q <= acc_mask;
        xrd_q  <= !we_i;
      end
      if (simple)        rdata_q <= we_i ? '0 : simple_rd;
      else if (eng_done) rdata_q <= xrd_q ? (eng_rdata & mask_q) : '0;
    end
  end

  assign ready_o = ready_q;
  assign rdata_o = rdata_q;

  p_ready_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_req_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_req_o |-> !ready_o);
  p_wr_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pr_req_o) && pr_wr_o) |-> (ctrl_o & CTRL_GATE_MASK) == GATE_WR);
  p_rd_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pr_req_o) && !pr_wr_o) |-> (ctrl_o & CTRL_GATE_MASK) == GATE_RD);
  p_cycle_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pr_req_o) |-> pr_addr_o == ($past(addr_i) == OFS_EADDR));
  p_tmo_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(eng_fail) |-> tmo);
endmodule

// File: tb/ppx_epp_gate_test.sv
`timescale 1ns/1ps
module ppx_epp_gate_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  pstat = 8'h00;
  logic        pr_ack = 1'b0;
  logic [7:0]  pr_rdata = 8'h00;
  logic        ready_o, data_upd_o, ctrl_upd_o, dir_chg_o;
  logic [31:0] rdata_o;
  logic [7:0]  data_o, ctrl_o, pr_wdata_o;
  logic        pr_req_o, pr_addr_o, pr_wr_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int         ack_dly = 1, wcnt = 0, nacc = 0;
  bit         req_seen = 0, alog = 0, wrlog = 0;
  logic [7:0] wlog [4];
  logic [7:0] rpat [4];

  logic [7:0] ref_ctrl = 8'hCC, ref_data = 8'hFF;
  bit         ref_tmo = 0;

  always #2.5 clk = ~clk;

  ppx_epp_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .ready_o(ready_o), .rdata_o(rdata_o), .pstat_i(pstat),
    .data_o(data_o), .data_upd_o(data_upd_o), .ctrl_o(ctrl_o), .ctrl_upd_o(ctrl_upd_o),
    .dir_chg_o(dir_chg_o), .pr_req_o(pr_req_o), .pr_addr_o(pr_addr_o), .pr_wr_o(pr_wr_o),
    .pr_wdata_o(pr_wdata_o), .pr_ack_i(pr_ack), .pr_rdata_i(pr_rdata)
  );

  // peripheral model: acks the ack_dly-th request cycle of each byte
  always @(negedge clk) begin
    pr_ack = 1'b0;
    if (pr_req_o) begin
      req_seen = 1;
      wcnt++;
      if (wcnt == ack_dly && nacc < 4) begin
        pr_ack   = 1'b1;
        pr_rdata = rpat[nacc];
        wlog[nacc] = pr_wdata_o;
        alog  = pr_addr_o;
        wrlog = pr_wr_o;
        nacc++;
        wcnt = 0;
      end
    end else wcnt = 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] width_ones(input logic [2:0] a, input logic [1:0] s);
    if (a != 3'd4 || s == 2'd0) return 32'h0000_00FF;
    if (s == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int nbytes(input logic [2:0] a, input logic [1:0] s);
    if (a != 3'd4 || s == 2'd0) return 1;
    if (s == 2'd1) return 2;
    return 4;
  endfunction

  // one host access plus checks against the reference model
  task automatic op(input bit w, input logic [2:0] a, input logic [1:0] s,
                    input logic [31:0] d, input int dly);
    logic [31:0] rd, expv;
    bit du, cu, dc, gate;
    int n;
    @(negedge clk);
    ack_dly = dly; nacc = 0; req_seen = 0; wcnt = 0;
    for (int i = 0; i < 4; i++) rpat[i] = 8'($urandom);
    pstat = 8'($urandom);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!ready_o && n < 200);
    rd = rdata_o; du = data_upd_o; cu = ctrl_upd_o; dc = dir_chg_o;
    req = 1'b0;
    chk("R12 ready seen", {31'd0, ready_o}, 32'd1);
    @(negedge clk);
    chk("R12 ready single pulse", {31'd0, ready_o}, 32'd0);

    case (a)
      3'd0: if (w) begin
              chk("R4 data event", {31'd0, du}, {31'd0, d[7:0] != ref_data});
              ref_data = d[7:0];
            end else chk("R4 data read", rd, {24'd0, ref_data});
      3'd1: if (w) begin
              if (d[0]) ref_tmo = 0;
              chk("R6 flag after status write", {31'd0, uut.tmo}, {31'd0, ref_tmo});
            end else chk("R5 status read", rd, {24'd0, pstat[7:1], ref_tmo});
      3'd2: if (w) begin
              chk("R2 ctrl event", {31'd0, cu}, {31'd0, (d[7:0] | 8'hC0) != ref_ctrl});
              chk("R3 dir event", {31'd0, dc}, {31'd0, ((d[7:0] ^ ref_ctrl) & 8'h20) != 0});
              ref_ctrl = d[7:0] | 8'hC0;
            end else chk("R2 ctrl read", rd, {24'd0, ref_ctrl});
      3'd3, 3'd4: begin
        gate = w ? ((ref_ctrl & 8'h2F) == 8'h04) : ((ref_ctrl & 8'h2F) == 8'h24);
        if (!gate) begin
          chk(w ? "R7 no request" : "R8 no request", {31'd0, req_seen}, 32'd0);
          if (!w) chk("R8 ones read", rd, width_ones(a, s));
        end else if (dly <= 16) begin
          chk("R10 byte count", nacc, nbytes(a, s));
          chk("R9 cycle select", {31'd0, alog}, {31'd0, a == 3'd3});
          chk("R9 direction", {31'd0, wrlog}, {31'd0, w});
          if (w) begin
            for (int i = 0; i < nbytes(a, s); i++) chk("R10 byte order", {24'd0, wlog[i]}, {24'd0, d[8*i +: 8]});
          end else begin
            expv = '0;
            for (int i = 0; i < nbytes(a, s); i++) expv[8*i +: 8] = rpat[i];
            chk("R10 read assembly", rd, expv);
          end
        end else begin
          ref_tmo = 1;
          chk("R11 no byte after timeout", nacc, 0);
          chk("R11 request seen", {31'd0, req_seen}, 32'd1);
          if (!w) chk("R11 ones read", rd, width_ones(a, s));
        end
      end
      default: if (!w) chk("R5 unused offset", rd, 32'h0000_00FF);
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #12 rst_n = 1'b1;
    // R1 reset values
    chk("R1 ctrl reset", {24'd0, ctrl_o}, 32'hCC);
    op(0, 3'd0, 0, 0, 1);
    op(0, 3'd2, 0, 0, 1);
    op(0, 3'd1, 0, 0, 1);
    chk("R1 flag reset", {31'd0, uut.tmo}, 32'd0);
    // R2/R3 control writes
    op(1, 3'd2, 0, 32'h04, 1);
    op(1, 3'd2, 0, 32'hC4, 1);
    op(1, 3'd2, 0, 32'h24, 1);
    op(1, 3'd2, 0, 32'h04, 1);
    // R4 data writes
    op(1, 3'd0, 0, 32'h5A, 1);
    op(1, 3'd0, 0, 32'h5A, 1);
    op(0, 3'd0, 0, 0, 1);
    // R9/R10 enhanced writes
    op(1, 3'd3, 0, 32'h0000_00A7, 2);
    op(1, 3'd4, 2, 32'h1122_3344, 1);
    op(1, 3'd4, 1, 32'h0000_BEEF, 3);
    // R11 boundary: 16 passes, 17 fails
    op(1, 3'd4, 2, 32'hCAFE_F00D, 16);
    op(0, 3'd1, 0, 0, 1);
    op(1, 3'd4, 2, 32'hCAFE_F00D, 17);
    op(0, 3'd1, 0, 0, 1);
    // R6 clear only with bit 0 set
    op(1, 3'd1, 0, 32'hFE, 1);
    op(1, 3'd1, 0, 32'h01, 1);
    // R7/R8 gate failures
    op(1, 3'd2, 0, 32'h05, 1);
    op(1, 3'd4, 2, 32'h1234_5678, 1);
    op(0, 3'd4, 1, 0, 1);
    op(0, 3'd4, 2, 0, 1);
    op(0, 3'd3, 0, 0, 1);
    // R8/R10 reads at direction+init
    op(1, 3'd2, 0, 32'h24, 1);
    op(0, 3'd4, 2, 0, 2);
    op(0, 3'd4, 1, 0, 1);
    op(0, 3'd3, 0, 0, 4);
    op(0, 3'd4, 2, 0, 18);
    op(1, 3'd4, 2, 0, 1);
    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 9);
      logic [31:0] d = $urandom;
      if (sel == 0) begin
        int c = $urandom_range(0, 2);
        op(1, 3'd2, 0, (c == 0) ? 32'h04 : (c == 1) ? 32'h24 : d, 1);
      end else if (sel == 1) op(1, 3'd1, 0, d, 1);
      else op($urandom_range(0, 1), 3'($urandom_range(0, 5)), 2'($urandom_range(0, 2)),
              d, $urandom_range(1, 18));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule